// File: doc/BRIEF.md
# Pipelined Pre-Add Multiply-Accumulate Slice

A parameterizable signed arithmetic slice. The sum of operands A and D, or A alone when the pre-adder is left out, is multiplied by operand B. A post-adder then adds the product to one of two values: the external C operand, or the slice's own registered result. Adding the registered result turns the slice into an accumulator. A load select replaces the fed-back result with C, so a new accumulation can start without a bubble. An overflow flag rises whenever the signed result is at or above a configured power of two.

Each stage has an optional pipeline register: the A chain (up to two deep), the B chain (up to two deep), D, the pre-adder result, the product and the result. Every register present has its own clock enable and a synchronous clear to zero. The two A stages share one clear input, and so do the two B stages. An absent register is a wire, so the latency equals the number of registers present on the path. All registers capture on the rising edge of one clock. An active-low asynchronous reset also clears every register.

Top module: `preadd_mac_slice`

## Requirements
- R1: While rst_ni is low, p_o is 0 and ovf_o is 0, whatever the other inputs are.
- R2: With the default parameters (one A stage, two B stages, one D stage, pre-adder register, product register and result register), p_o equals the two's complement value (a_i + d_i) * b_i + c_i. Here a_i, b_i and d_i are the values present at edge n+1, and c_i is the value present at edge n+4. The result is visible after edge n+4. This holds with accum_i=0.
- R3: With accum_i=1 and load_i=0, the result register captures its own previous value plus the product.
- R4: With accum_i=1 and load_i=1, the fed-back value is replaced by c_i, so the result register captures c_i plus the product.
- R5: A register whose clock enable is low, and whose clear is low, keeps its value across the edge.
- R6: A register whose synchronous clear is high becomes zero at that edge, even when its clock enable is low.
- R7: srst_a_i clears both A stages and srst_b_i clears both B stages in the same edge.
- R8: ovf_o is 1 exactly when the signed value of p_o is at least 2^OVF_K. A negative result never sets it.
- R9: A stage whose register parameter is 0 is a combinational pass-through. With every register parameter at 0, p_o = (a_i + d_i) * b_i + c_i in the same cycle.
- R10: Operands are two's complement. The product is sign-extended to the P_W-bit post-adder width, so negative results appear as negative values on p_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | A_W | Operand A (signed) |
| b_i | input | B_W | Operand B (signed) |
| c_i | input | P_W | Operand C / reload value (signed) |
| d_i | input | D_W | Operand D, pre-adder input (signed) |
| ce_a1_i | input | 1 | Enable, first A stage |
| ce_a2_i | input | 1 | Enable, last A stage |
| ce_b1_i | input | 1 | Enable, first B stage |
| ce_b2_i | input | 1 | Enable, last B stage |
| ce_d_i | input | 1 | Enable, D stage |
| ce_ad_i | input | 1 | Enable, pre-adder register |
| ce_m_i | input | 1 | Enable, product register |
| ce_p_i | input | 1 | Enable, result register |
| srst_a_i | input | 1 | Synchronous clear, both A stages |
| srst_b_i | input | 1 | Synchronous clear, both B stages |
| srst_d_i | input | 1 | Synchronous clear, D stage |
| srst_ad_i | input | 1 | Synchronous clear, pre-adder register |
| srst_m_i | input | 1 | Synchronous clear, product register |
| srst_p_i | input | 1 | Synchronous clear, result register |
| accum_i | input | 1 | 1: add fed-back result instead of C |
| load_i | input | 1 | 1: override feedback with C (reload) |
| p_o | output | P_W | Result (signed) |
| ovf_o | output | 1 | Result is at least 2^OVF_K |

## Verification
The assertions check four behaviours on every cycle. A present register clears on its synchronous clear and holds when its enable is low. The result register steps by exactly the product in accumulate mode and reloads to C plus the product under load override. A negative result never raises the overflow flag. The bench's scenarios are needed for the end-to-end latency across the chains and for the timing of C. They also cover the shared clears of both A and both B stages, the exact overflow boundary, and the zero-latency variant with every register removed.

// File: rtl/preadd_mac_pkg.sv
package preadd_mac_pkg;

  typedef enum logic {
    ADDEND_EXT      = 1'b0,
    ADDEND_FEEDBACK = 1'b1
  } addend_sel_e;

  // Feedback only when accumulating and not reloading.
  function automatic addend_sel_e pick_addend(input logic accum, input logic load);
    return (accum && !load) ? ADDEND_FEEDBACK : ADDEND_EXT;
  endfunction

endpackage

// File: rtl/mac_pipe_reg.sv
module mac_pipe_reg #(
  parameter int W  = 8,
  parameter int EN = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce_i,
  input  logic         srst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  if (EN != 0) begin : g_reg
    logic [W-1:0] q_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q_q <= '0;
      else if (srst_i)  q_q <= '0;
      else if (ce_i)    q_q <= d_i;
    end

    assign q_o = q_q;

    AST_SRST_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      srst_i |=> (q_o == '0)); // R6

    AST_CE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!srst_i && !ce_i) |=> (q_o == $past(q_o))); // R5
  end else begin : g_wire
    logic unused_ctl;
    assign unused_ctl = ^{clk_i, rst_ni, ce_i, srst_i};
    assign q_o = d_i;
  end

endmodule

// File: rtl/mac_input_path.sv
module mac_input_path #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce1_i,
  input  logic         ce2_i,
  input  logic         srst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  localparam int EN1 = (STAGES >= 2) ? 1 : 0;
  localparam int EN2 = (STAGES >= 1) ? 1 : 0;

  logic [W-1:0] s1;

  // Both stages share one clear so they always empty together.
  mac_pipe_reg #(.W(W), .EN(EN1)) u_stage1 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ce_i  (ce1_i),
    .srst_i(srst_i),
    .d_i   (d_i),
    .q_o   (s1)
  );

  mac_pipe_reg #(.W(W), .EN(EN2)) u_stage2 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ce_i  (ce2_i),
    .srst_i(srst_i),
    .d_i   (s1),
    .q_o   (q_o)
  );

endmodule

// File: rtl/mac_preadd_mult.sv
module mac_preadd_mult #(
  parameter int A_W        = 30,
  parameter int D_W        = 25,
  parameter int AD_W       = 25,
  parameter int B_W        = 18,
  parameter int USE_PREADD = 1,
  parameter int AD_REG     = 1,
  parameter int M_REG      = 1,
  localparam int MA_W      = (USE_PREADD != 0) ? AD_W : A_W,
  localparam int M_W       = MA_W + B_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [A_W-1:0] a_i,
  input  logic [D_W-1:0] d_i,
  input  logic [B_W-1:0] b_i,
  input  logic           ce_ad_i,
  input  logic           srst_ad_i,
  input  logic           ce_m_i,
  input  logic           srst_m_i,
  output logic [M_W-1:0] m_o
);

  logic signed [MA_W-1:0] mul_a;
  logic signed [MA_W-1:0] ad_q;
  logic signed [M_W-1:0]  mul_ax;
  logic signed [M_W-1:0]  mul_bx;
  logic signed [M_W-1:0]  prod;
  logic signed [B_W-1:0]  b_sgn;

  if (USE_PREADD != 0) begin : g_preadd
    logic signed [AD_W-1:0] a_lo;
    logic signed [AD_W-1:0] d_ext;
    logic signed [D_W-1:0]  d_sgn;
    logic unused_a_hi;
    assign a_lo  = a_i[AD_W-1:0];
    assign d_sgn = d_i;
    assign d_ext = AD_W'(d_sgn);
    assign mul_a = a_lo + d_ext;   // wraps at AD_W
    assign unused_a_hi = ^a_i;
  end else begin : g_nopre
    logic unused_d;
    assign mul_a    = a_i;         // AD slot serves as the last A stage
    assign unused_d = ^d_i;
  end

  mac_pipe_reg #(.W(MA_W), .EN(AD_REG)) u_ad_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ce_i  (ce_ad_i),
    .srst_i(srst_ad_i),
    .d_i   (mul_a),
    .q_o   (ad_q)
  );

  assign b_sgn  = b_i;
  assign mul_ax = M_W'(ad_q);
  assign mul_bx = M_W'(b_sgn);
  assign prod   = mul_ax * mul_bx;

  mac_pipe_reg #(.W(M_W), .EN(M_REG)) u_m_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ce_i  (ce_m_i),
    .srst_i(srst_m_i),
    .d_i   (prod),
    .q_o   (m_o)
  );

endmodule

// File: rtl/mac_post_acc.sv
module mac_post_acc
  import preadd_mac_pkg::*;
#(
  parameter int M_W         = 43,
  parameter int P_W         = 48,
  parameter int USE_POSTADD = 1,
  parameter int P_REG       = 1,
  parameter int OVF_K       = 20
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [M_W-1:0] m_i,
  input  logic [P_W-1:0] c_i,
  input  logic           accum_i,
  input  logic           load_i,
  input  logic           ce_p_i,
  input  logic           srst_p_i,
  output logic [P_W-1:0] p_o,
  output logic           ovf_o
);

  localparam logic signed [P_W-1:0] OVF_THR = P_W'(1) << OVF_K;

  logic signed [M_W-1:0] m_sgn;
  logic signed [P_W-1:0] m_ext;
  logic signed [P_W-1:0] addend;
  logic signed [P_W-1:0] sum;
  logic signed [P_W-1:0] p_sgn;

  assign m_sgn = m_i;
  assign m_ext = P_W'(m_sgn);

  if (USE_POSTADD != 0 && P_REG != 0) begin : g_fbk
    addend_sel_e sel;
    assign sel    = pick_addend(accum_i, load_i);
    assign addend = (sel == ADDEND_FEEDBACK) ? p_sgn : c_i;
  end else if (USE_POSTADD != 0) begin : g_ext
    // No result register: feedback would be a combinational loop.
    logic unused_mode;
    assign unused_mode = accum_i ^ load_i;
    assign addend      = c_i;
  end else begin : g_none
    logic unused_c;
    assign unused_c = ^{c_i, accum_i, load_i};
    assign addend   = '0;
  end

  assign sum = m_ext + addend;

  mac_pipe_reg #(.W(P_W), .EN(P_REG)) u_p_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ce_i  (ce_p_i),
    .srst_i(srst_p_i),
    .d_i   (sum),
    .q_o   (p_sgn)
  );

  assign p_o   = p_sgn;
  assign ovf_o = (p_sgn >= OVF_THR);

  if (USE_POSTADD != 0 && P_REG != 0) begin : g_chk
    AST_ACCUM_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ce_p_i && !srst_p_i && accum_i && !load_i)
        |=> (p_sgn == $past(p_sgn) + $past(m_ext))); // R3

    AST_LOAD_OVERRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ce_p_i && !srst_p_i && accum_i && load_i)
        |=> (p_sgn == $past(c_i) + $past(m_ext))); // R4
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_o[P_W-1] |-> !ovf_o); // R8

endmodule

// File: rtl/preadd_mac_slice.sv
module preadd_mac_slice #(
  parameter int A_W         = 30,
  parameter int B_W         = 18,
  parameter int D_W         = 25,
  parameter int AD_W        = 25,
  parameter int P_W         = 48,
  parameter int USE_PREADD  = 1,
  parameter int USE_POSTADD = 1,
  parameter int A_STAGES    = 1,
  parameter int B_STAGES    = 2,
  parameter int D_REG       = 1,
  parameter int AD_REG      = 1,
  parameter int M_REG       = 1,
  parameter int P_REG       = 1,
  parameter int OVF_K       = 20
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  input  logic [P_W-1:0] c_i,
  input  logic [D_W-1:0] d_i,
  input  logic           ce_a1_i,
  input  logic           ce_a2_i,
  input  logic           ce_b1_i,
  input  logic           ce_b2_i,
  input  logic           ce_d_i,
  input  logic           ce_ad_i,
  input  logic           ce_m_i,
  input  logic           ce_p_i,
  input  logic           srst_a_i,
  input  logic           srst_b_i,
  input  logic           srst_d_i,
  input  logic           srst_ad_i,
  input  logic           srst_m_i,
  input  logic           srst_p_i,
  input  logic           accum_i,
  input  logic           load_i,
  output logic [P_W-1:0] p_o,
  output logic           ovf_o
);

  localparam int MA_W = (USE_PREADD != 0) ? AD_W : A_W;
  localparam int M_W  = MA_W + B_W;

  logic [A_W-1:0] a_q;
  logic [B_W-1:0] b_q;
  logic [D_W-1:0] d_q;
  logic [M_W-1:0] m_q;

  mac_input_path #(.W(A_W), .STAGES(A_STAGES)) u_a_path (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ce1_i (ce_a1_i),
    .ce2_i (ce_a2_i),
    .srst_i(srst_a_i),
    .d_i   (a_i),
    .q_o   (a_q)
  );

  mac_input_path #(.W(B_W), .STAGES(B_STAGES)) u_b_path (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ce1_i (ce_b1_i),
    .ce2_i (ce_b2_i),
    .srst_i(srst_b_i),
    .d_i   (b_i),
    .q_o   (b_q)
  );

  mac_input_path #(.W(D_W), .STAGES(D_REG)) u_d_path (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ce1_i (ce_d_i),
    .ce2_i (ce_d_i),
    .srst_i(srst_d_i),
    .d_i   (d_i),
    .q_o   (d_q)
  );

  mac_preadd_mult #(
    .A_W       (A_W),
    .D_W       (D_W),
    .AD_W      (AD_W),
    .B_W       (B_W),
    .USE_PREADD(USE_PREADD),
    .AD_REG    (AD_REG),
    .M_REG     (M_REG)
  ) u_mul (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_i      (a_q),
    .d_i      (d_q),
    .b_i      (b_q),
    .ce_ad_i  (ce_ad_i),
    .srst_ad_i(srst_ad_i),
    .ce_m_i   (ce_m_i),
    .srst_m_i (srst_m_i),
    .m_o      (m_q)
  );

  mac_post_acc #(
    .M_W        (M_W),
    .P_W        (P_W),
    .USE_POSTADD(USE_POSTADD),
    .P_REG      (P_REG),
    .OVF_K      (OVF_K)
  ) u_post (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .m_i     (m_q),
    .c_i     (c_i),
    .accum_i (accum_i),
    .load_i  (load_i),
    .ce_p_i  (ce_p_i),
    .srst_p_i(srst_p_i),
    .p_o     (p_o),
    .ovf_o   (ovf_o)
  );

endmodule

// File: tb/preadd_mac_slice_tb.sv
module preadd_mac_slice_tb;

  localparam int A_W = 30, B_W = 18, D_W = 25, P_W = 48, K = 20;
  localparam int N = 9;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [A_W-1:0] a_i = '0;
  logic [B_W-1:0] b_i = '0;
  logic [P_W-1:0] c_i = '0;
  logic [D_W-1:0] d_i = '0;
  logic ce_a1_i = 1, ce_a2_i = 1, ce_b1_i = 1, ce_b2_i = 1;
  logic ce_d_i = 1, ce_ad_i = 1, ce_m_i = 1, ce_p_i = 1;
  logic srst_a_i = 0, srst_b_i = 0, srst_d_i = 0, srst_ad_i = 0, srst_m_i = 0, srst_p_i = 0;
  logic accum_i = 0, load_i = 0;
  logic [P_W-1:0] p_o, p_comb;
  logic ovf_o, ovf_comb;

  always #4 clk = ~clk;  // 125 MHz

  preadd_mac_slice u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .c_i(c_i), .d_i(d_i),
    .ce_a1_i(ce_a1_i), .ce_a2_i(ce_a2_i), .ce_b1_i(ce_b1_i), .ce_b2_i(ce_b2_i),
    .ce_d_i(ce_d_i), .ce_ad_i(ce_ad_i), .ce_m_i(ce_m_i), .ce_p_i(ce_p_i),
    .srst_a_i(srst_a_i), .srst_b_i(srst_b_i), .srst_d_i(srst_d_i),
    .srst_ad_i(srst_ad_i), .srst_m_i(srst_m_i), .srst_p_i(srst_p_i),
    .accum_i(accum_i), .load_i(load_i), .p_o(p_o), .ovf_o(ovf_o)
  );

  preadd_mac_slice #(
    .A_STAGES(0), .B_STAGES(0), .D_REG(0), .AD_REG(0), .M_REG(0), .P_REG(0)
  ) u_dut_comb (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .c_i(c_i), .d_i(d_i),
    .ce_a1_i(ce_a1_i), .ce_a2_i(ce_a2_i), .ce_b1_i(ce_b1_i), .ce_b2_i(ce_b2_i),
    .ce_d_i(ce_d_i), .ce_ad_i(ce_ad_i), .ce_m_i(ce_m_i), .ce_p_i(ce_p_i),
    .srst_a_i(srst_a_i), .srst_b_i(srst_b_i), .srst_d_i(srst_d_i),
    .srst_ad_i(srst_ad_i), .srst_m_i(srst_m_i), .srst_p_i(srst_p_i),
    .accum_i(accum_i), .load_i(load_i), .p_o(p_comb), .ovf_o(ovf_comb)
  );

  int checks = 0, fails = 0, tick = 0;
  bit done = 0;

  int     q_due[$];
  longint q_p[$];
  longint q_ovf[$];
  string  q_tag[$];

  longint ia[N], ib[N], id[N], ic[N];
  bit     iacc[N], iload[N];
  string  itag[N];

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic longint pval();
    return longint'($signed(p_o));
  endfunction

  always @(posedge clk) tick <= tick + 1;

  // monitor
  always @(negedge clk) begin
    if (q_due.size() > 0 && q_due[0] == tick) begin
      chk(q_tag[0], pval(), q_p[0]);
      chk("R8 ovf", longint'(ovf_o), q_ovf[0]);
      void'(q_due.pop_front());
      void'(q_p.pop_front());
      void'(q_ovf.pop_front());
      void'(q_tag.pop_front());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    longint exp_p, prod;
    ia = '{3, -7, 10, 1, 5, 2, 1000, 1023, -1000};
    id = '{4, 2, 10, 1, 0, 3, 24, 0, 0};
    ib = '{5, 6, -3, 1, 100, 4, 1024, 1024, 5000};
    ic = '{100, -50, 0, 0, 1000, 0, 0, 0, 0};
    iacc  = '{0, 0, 1, 1, 1, 1, 0, 0, 0};
    iload = '{0, 0, 0, 0, 1, 0, 0, 0, 0};
    itag = '{"R2 plain", "R10 negative", "R3 accumulate", "R3 accumulate",
             "R4 load override", "R3 accumulate", "R8 at threshold",
             "R8 below threshold", "R10 negative product"};

    // R1: reset holds outputs at zero with busy inputs
    a_i = 30'd77; b_i = 18'd9; d_i = 25'd3; c_i = 48'd12345;
    cycles(3);
    chk("R1 p in reset", pval(), 0);
    chk("R1 ovf in reset", longint'(ovf_o), 0);
    a_i = '0; b_i = '0; d_i = '0; c_i = '0;
    rst_ni = 1'b1;
    cycles(1);
    chk("R1 p after reset", pval(), 0);

    // stream: operands at step i, post-adder controls at step i+3
    exp_p = 0;
    for (int i = 0; i < N + 4; i++) begin
      int j;
      cycles(1);
      j = i - 3;
      if (i < N) begin
        a_i = A_W'(ia[i]); b_i = B_W'(ib[i]); d_i = D_W'(id[i]);
      end else begin
        a_i = '0; b_i = '0; d_i = '0;
      end
      if (j >= 0 && j < N) begin
        c_i = P_W'(ic[j]); accum_i = iacc[j]; load_i = iload[j];
        prod = (ia[j] + id[j]) * ib[j];
        if (iacc[j] && !iload[j]) exp_p = exp_p + prod;
        else exp_p = ic[j] + prod;
        q_due.push_back(tick + 1);
        q_p.push_back(exp_p);
        q_ovf.push_back((exp_p >= (64'sd1 <<< K)) ? 1 : 0);
        q_tag.push_back(itag[j]);
      end else begin
        c_i = '0; accum_i = 0; load_i = 0;
      end
    end
    cycles(3);
    chk("R2 scoreboard drained", longint'(q_due.size()), 0);

    // steady operands
    a_i = 30'd5; d_i = '0; b_i = 18'd3; c_i = '0; accum_i = 0; load_i = 0;
    cycles(6);
    chk("R2 steady", pval(), 15);

    // R5: result enable low holds
    ce_p_i = 0; a_i = 30'd9;
    cycles(6);
    chk("R5 p hold", pval(), 15);
    ce_p_i = 1;
    cycles(1);
    chk("R5 p release", pval(), 27);

    // R5: A stage enable low holds
    ce_a2_i = 0; a_i = 30'd2;
    cycles(6);
    chk("R5 a hold", pval(), 27);
    ce_a2_i = 1;
    cycles(6);
    chk("R5 a release", pval(), 6);
    a_i = 30'd5;
    cycles(6);
    chk("R2 restore", pval(), 15);

    // R6: clear beats a low enable
    ce_p_i = 0; srst_p_i = 1;
    cycles(1);
    chk("R6 p clear with ce low", pval(), 0);
    srst_p_i = 0;
    cycles(1);
    chk("R5 p stays cleared", pval(), 0);
    ce_p_i = 1;
    cycles(1);
    chk("R6 p reload", pval(), 15);

    // R6: product register clear
    srst_m_i = 1;
    cycles(1);
    srst_m_i = 0;
    cycles(1);
    chk("R6 m clear", pval(), 0);
    cycles(2);
    chk("R6 m recover", pval(), 15);

    // R7: A clear
    srst_a_i = 1;
    cycles(1);
    srst_a_i = 0;
    cycles(3);
    chk("R7 a clear", pval(), 0);
    cycles(4);
    chk("R7 a recover", pval(), 15);

    // R7: B clear empties both stages
    srst_b_i = 1;
    cycles(1);
    srst_b_i = 0;
    cycles(2);
    chk("R7 b2 clear", pval(), 0);
    cycles(1);
    chk("R7 b1 clear", pval(), 0);
    cycles(4);
    chk("R7 b recover", pval(), 15);

    // R9: all-wire variant, same-cycle result
    a_i = 30'd7; d_i = -25'sd2; b_i = -18'sd9; c_i = 48'd40;
    #1;
    chk("R9 comb value", longint'($signed(p_comb)), -5);
    chk("R8 comb ovf low", longint'(ovf_comb), 0);
    cycles(1);
    a_i = 30'd1024; d_i = '0; b_i = 18'd1024; c_i = '0;
    #1;
    chk("R9 comb threshold", longint'($signed(p_comb)), 64'sd1 <<< K);
    chk("R8 comb ovf at 2^K", longint'(ovf_comb), 1);
    cycles(1);
    a_i = '0; b_i = '0; c_i = P_W'((64'sd1 <<< K) - 1);
    #1;
    chk("R8 comb ovf just below", longint'(ovf_comb), 0);

    cycles(2);
    finish_run();
  end

endmodule